// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block chooses the reply of a low-speed USB function with three endpoints. Endpoint 0 is a bidirectional control endpoint. Endpoints 1 and 2 only send interrupt IN data. A serial interface engine delivers decoded events to the block: a token with its kind, device address and endpoint number, a data packet with its data PID, byte count and error indication, and the host's ACK after IN data. Firmware supplies the per-endpoint control bits: ready set pulses, toggle, stall, configured and control-read. The block sets those ready flags back to zero when a transfer completes.

For every event the block produces one registered reply, one cycle later. The reply is a data packet (DATA0 or DATA1 plus a byte count), an ACK, a NAK, a STALL, or no reply at all. It also drives the receive storage write enable, the completion pulses and the endpoint 0 status fields. Bit stuffing, CRC, line coding and the storage itself belong to other blocks.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset the device address is 0, all ready flags are 0, the status fields are 0, and no reply, write enable or completion pulse is driven.
- R2: A token whose address differs from the device address gets no reply and starts no transfer. An address write loads the address. A USB bus reset pulse sets it back to 0.
- R3: A good data packet after an endpoint 0 SETUP token is always accepted, whatever the receive-ready and stall bits are. Acceptance means: reply ACK (code 2), pulse the write enable and the receive-done output, clear receive-ready, and set the status to setup=1, dir=0, err=0, toggle = received PID (1 = DATA1) and count = received count.
- R4: A good data packet after an endpoint 0 OUT token is accepted the same way, with setup=0, only when receive-ready is 1 and endpoint 0 stall is 0.
- R5: With receive-ready at 0 and no stall rule hit, an endpoint 0 OUT data packet gets NAK (code 3). Nothing is written and the status does not change.
- R6: An endpoint's stall bit forces STALL (code 4) on IN to that endpoint and on endpoint 0 OUT data, even when the ready flag is set.
- R7: While control-read is 1, endpoint 0 OUT data with DATA0 or a nonzero count gets STALL. DATA1 with count 0 is handled as in R4 and R5.
- R8: An IN token to an enabled endpoint whose transmit-ready is 1 and stall is 0 gets DATA1 (code 1) if its toggle is 1, else DATA0 (code 0), with that endpoint's transmit count. With transmit-ready at 0 it gets NAK.
- R9: Transmit-ready is cleared, and the matching transmit-done bit pulses, only when the host ACK follows the data reply. A following token without an ACK leaves the flag set. An acknowledged endpoint 0 IN sets status dir=1.
- R10: Endpoints 1 and 2 reply only while configured. OUT or SETUP tokens to them, and any token to endpoint 3 or above, get no reply.
- R11: A data packet flagged with an error gets no reply and no write, sets status err=1, and leaves the ready flags unchanged. The next accepted packet clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busResetI | input | 1 | USB bus reset pulse |
| addrWrI | input | 1 | Load device address |
| addrI | input | 7 | New device address |
| tokValidI | input | 1 | Token event pulse |
| tokKindI | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tokAddrI | input | 7 | Token address |
| tokEpI | input | 4 | Token endpoint |
| dataValidI | input | 1 | Data packet event pulse |
| dataPid1I | input | 1 | Received data PID is DATA1 |
| dataCntI | input | 4 | Received byte count, 0 to 8 |
| dataErrI | input | 1 | CRC or PID check error on the packet |
| hostAckI | input | 1 | Host ACK after IN data |
| rc0RdySetI | input | 1 | Firmware sets endpoint 0 receive-ready |
| txRdySetI | input | 3 | Firmware sets transmit-ready, bit per endpoint |
| toggleI | input | 3 | Transmit toggle per endpoint |
| stallI | input | 3 | Stall per endpoint |
| cfgI | input | 2 | Configured bits for endpoints 1 (bit 0) and 2 (bit 1) |
| ctrlRdI | input | 1 | Control-read transfer in progress |
| txCntI | input | 12 | Transmit counts, endpoint e at bits 4e+3..4e |
| respValidO | output | 1 | Reply pulse |
| respKindO | output | 3 | Reply code: 0 DATA0, 1 DATA1, 2 ACK, 3 NAK, 4 STALL |
| respCntO | output | 4 | Byte count of a data reply |
| rxFifoWeO | output | 1 | Endpoint 0 receive storage write enable |
| rxDoneO | output | 1 | Endpoint 0 receive-complete pulse |
| txDoneO | output | 3 | Transmit-complete pulses per endpoint |
| rc0RdyO | output | 1 | Endpoint 0 receive-ready flag |
| txRdyO | output | 3 | Transmit-ready flags |
| devAddrO | output | 7 | Device address |
| stTglO | output | 1 | Status: last received toggle |
| stErrO | output | 1 | Status: data error |
| stDirO | output | 1 | Status: last direction, 1 = IN |
| stSetupO | output | 1 | Status: last transfer was SETUP |
| stCntO | output | 4 | Status: last received count |

## Verification
The bench sends SETUP data while receive-ready is clear and stall is set. A design that applied the OUT rules to SETUP would NAK or STALL the packet there, where it must ACK and write it. It also checks the control-read rule with DATA0 and count 0, DATA1 with a count, and the legal DATA1 with count 0. A wrong test would either stall the legal zero-length status packet or accept an illegal one. A second token arrives between an IN data reply and any host ACK, and corrupt packets are sent while receive-ready is set. Designs that clear ready flags too early, or on bad data, fail there. Foreign addresses, unconfigured endpoints, OUT tokens to IN-only endpoints and endpoint numbers above 2 must all stay silent. A design that decoded only the low endpoint bits, or ignored the configured bits, would answer them.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;
  localparam int HS_NUM_EP = 3;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2
  } tok_e;

  typedef enum logic [2:0] {
    RSP_DATA0 = 3'd0,
    RSP_DATA1 = 3'd1,
    RSP_ACK   = 3'd2,
    RSP_NAK   = 3'd3,
    RSP_STALL = 3'd4
  } rsp_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic                 rxTake;
    logic                 rxSetup;
    logic                 rxBad;
    logic [HS_NUM_EP-1:0] txAck;
  } strobe_t;
endpackage

// File: rtl/usb_hs_ctrl.sv
module usb_hs_ctrl
  import usb_hs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int CNT_W  = 4,
  parameter int NUM_EP = HS_NUM_EP
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busResetI,
  input  logic                    tokValidI,
  input  logic [1:0]              tokKindI,
  input  logic [ADDR_W-1:0]       tokAddrI,
  input  logic [EP_W-1:0]         tokEpI,
  input  logic                    dataValidI,
  input  logic                    dataPid1I,
  input  logic [CNT_W-1:0]        dataCntI,
  input  logic                    dataErrI,
  input  logic                    hostAckI,
  input  logic [ADDR_W-1:0]       devAddrI,
  input  logic                    rc0RdyI,
  input  logic [NUM_EP-1:0]       txRdyI,
  input  logic [NUM_EP-1:0]       toggleI,
  input  logic [NUM_EP-1:0]       stallI,
  input  logic [NUM_EP-1:0]       enableI,
  input  logic                    ctrlRdI,
  input  logic [NUM_EP*CNT_W-1:0] txCntI,
  output logic                    respValidO,
  output rsp_e                    respKindO,
  output logic [CNT_W-1:0]        respCntO,
  output strobe_t                 strobeO
);
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP_DATA, ST_OUT_DATA, ST_WAIT_ACK} state_e;

  state_e            state, stateNext;
  logic [NUM_EP-1:0] ackEp, ackEpNext, epHit, inSel;
  logic              txHit, stallHit, tglHit, addrHit, outRule;
  logic [CNT_W-1:0]  cntHit;
  logic              rspV;
  rsp_e              rspK;
  logic [CNT_W-1:0]  rspC;

  genvar e;
  generate
    for (e = 0; e < NUM_EP; e++) begin : g_hit
      assign epHit[e] = (tokEpI == EP_W'(e));
    end
  endgenerate

  assign inSel    = epHit & enableI;
  assign txHit    = |(inSel & txRdyI);
  assign stallHit = |(inSel & stallI);
  assign tglHit   = |(inSel & toggleI);
  assign addrHit  = (tokAddrI == devAddrI);
  assign outRule  = stallI[0] || (ctrlRdI && (!dataPid1I || dataCntI != '0));

  always_comb begin
    cntHit = '0;
    for (int i = 0; i < NUM_EP; i++)
      if (inSel[i]) cntHit = cntHit | txCntI[i*CNT_W +: CNT_W];
  end

  always_comb begin
    stateNext = state;
    ackEpNext = ackEp;
    rspV      = 1'b0;
    rspK      = RSP_DATA0;
    rspC      = '0;
    strobeO   = '0;
    if (busResetI) begin
      stateNext = ST_IDLE;
    end else if (tokValidI) begin
      stateNext = ST_IDLE;
      if (addrHit) begin
        if (tokKindI == TOK_SETUP && epHit[0]) stateNext = ST_SETUP_DATA;
        else if (tokKindI == TOK_OUT && epHit[0]) stateNext = ST_OUT_DATA;
        else if (tokKindI == TOK_IN && |inSel) begin
          rspV = 1'b1;
          if (stallHit) rspK = RSP_STALL;
          else if (!txHit) rspK = RSP_NAK;
          else begin
            rspK      = tglHit ? RSP_DATA1 : RSP_DATA0;
            rspC      = cntHit;
            stateNext = ST_WAIT_ACK;
            ackEpNext = inSel;
          end
        end
      end
    end else if (dataValidI && (state == ST_SETUP_DATA || state == ST_OUT_DATA)) begin
      stateNext = ST_IDLE;
      if (dataErrI) strobeO.rxBad = 1'b1;
      else if (state == ST_SETUP_DATA) begin
        strobeO.rxTake  = 1'b1;
        strobeO.rxSetup = 1'b1;
        rspV = 1'b1;
        rspK = RSP_ACK;
      end else if (outRule) begin
        rspV = 1'b1;
        rspK = RSP_STALL;
      end else if (!rc0RdyI) begin
        rspV = 1'b1;
        rspK = RSP_NAK;
      end else begin
        strobeO.rxTake = 1'b1;
        rspV = 1'b1;
        rspK = RSP_ACK;
      end
    end else if (hostAckI && state == ST_WAIT_ACK) begin
      strobeO.txAck = ackEp;
      stateNext     = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ackEp      <= '0;
      respValidO <= 1'b0;
      respKindO  <= RSP_DATA0;
      respCntO   <= '0;
    end else begin
      state      <= stateNext;
      ackEp      <= ackEpNext;
      respValidO <= rspV;
      respKindO  <= rspK;
      respCntO   <= rspC;
    end
  end

  // R6: a stalled endpoint 0 answers IN with STALL
  assert_stall_in_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tokValidI && !busResetI && tokKindI == TOK_IN && tokAddrI == devAddrI &&
     tokEpI == '0 && stallI[0]) |=> (respValidO && respKindO == RSP_STALL));

  // R5: OUT data with receive-ready clear and no stall rule gets NAK
  assert_nak_not_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataValidI && !tokValidI && !busResetI && state == ST_OUT_DATA && !dataErrI &&
     !stallI[0] && !ctrlRdI && !rc0RdyI) |=> (respValidO && respKindO == RSP_NAK));

  // R11: a corrupt packet is never answered
  assert_err_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dataValidI && dataErrI && !tokValidI && !hostAckI) |=> !respValidO);

  // R10: endpoint numbers beyond the implemented set are silent
  assert_high_ep_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tokValidI && tokEpI >= EP_W'(NUM_EP)) |=> !respValidO);
endmodule

// File: rtl/usb_hs_dp.sv
module usb_hs_dp
  import usb_hs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 4,
  parameter int NUM_EP = HS_NUM_EP
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busResetI,
  input  logic              addrWrI,
  input  logic [ADDR_W-1:0] addrI,
  input  logic              dataPid1I,
  input  logic [CNT_W-1:0]  dataCntI,
  input  logic              rc0RdySetI,
  input  logic [NUM_EP-1:0] txRdySetI,
  input  strobe_t           strobeI,
  output logic [ADDR_W-1:0] devAddrO,
  output logic              rc0RdyO,
  output logic [NUM_EP-1:0] txRdyO,
  output logic              rxFifoWeO,
  output logic              rxDoneO,
  output logic [NUM_EP-1:0] txDoneO,
  output logic              stTglO,
  output logic              stErrO,
  output logic              stDirO,
  output logic              stSetupO,
  output logic [CNT_W-1:0]  stCntO
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) devAddrO <= '0;
    else if (busResetI) devAddrO <= '0;
    else if (addrWrI) devAddrO <= addrI;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rc0RdyO   <= 1'b0;
      rxFifoWeO <= 1'b0;
      rxDoneO   <= 1'b0;
      stTglO    <= 1'b0;
      stErrO    <= 1'b0;
      stDirO    <= 1'b0;
      stSetupO  <= 1'b0;
      stCntO    <= '0;
    end else begin
      rxFifoWeO <= strobeI.rxTake;
      rxDoneO   <= strobeI.rxTake;
      if (strobeI.rxTake) rc0RdyO <= 1'b0;
      else if (rc0RdySetI) rc0RdyO <= 1'b1;
      if (strobeI.rxTake) begin
        stTglO   <= dataPid1I;
        stErrO   <= 1'b0;
        stDirO   <= 1'b0;
        stSetupO <= strobeI.rxSetup;
        stCntO   <= dataCntI;
      end
      if (strobeI.rxBad) stErrO <= 1'b1;
      if (strobeI.txAck[0]) stDirO <= 1'b1;
    end
  end

  genvar e;
  generate
    for (e = 0; e < NUM_EP; e++) begin : g_tx
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          txRdyO[e]  <= 1'b0;
          txDoneO[e] <= 1'b0;
        end else begin
          txDoneO[e] <= strobeI.txAck[e];
          if (strobeI.txAck[e]) txRdyO[e] <= 1'b0;
          else if (txRdySetI[e]) txRdyO[e] <= 1'b1;
        end
      end

      // R9: transmit-ready only falls after a host acknowledge
      assert_txrdy_ack_only_R9: assert property (@(posedge clk) disable iff (!rstN)
        $fell(txRdyO[e]) |-> $past(strobeI.txAck[e]));
    end
  endgenerate

  // R3: taking a packet clears receive-ready and pulses the done flag
  assert_take_clears_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobeI.rxTake |=> (!rc0RdyO && rxDoneO && rxFifoWeO));

  // R2: bus reset returns the device address to zero
  assert_busreset_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    busResetI |=> (devAddrO == '0));
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_hs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int CNT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busResetI,
  input  logic                       addrWrI,
  input  logic [ADDR_W-1:0]          addrI,
  input  logic                       tokValidI,
  input  logic [1:0]                 tokKindI,
  input  logic [ADDR_W-1:0]          tokAddrI,
  input  logic [EP_W-1:0]            tokEpI,
  input  logic                       dataValidI,
  input  logic                       dataPid1I,
  input  logic [CNT_W-1:0]           dataCntI,
  input  logic                       dataErrI,
  input  logic                       hostAckI,
  input  logic                       rc0RdySetI,
  input  logic [HS_NUM_EP-1:0]       txRdySetI,
  input  logic [HS_NUM_EP-1:0]       toggleI,
  input  logic [HS_NUM_EP-1:0]       stallI,
  input  logic [HS_NUM_EP-2:0]       cfgI,
  input  logic                       ctrlRdI,
  input  logic [HS_NUM_EP*CNT_W-1:0] txCntI,
  output logic                       respValidO,
  output logic [2:0]                 respKindO,
  output logic [CNT_W-1:0]           respCntO,
  output logic                       rxFifoWeO,
  output logic                       rxDoneO,
  output logic [HS_NUM_EP-1:0]       txDoneO,
  output logic                       rc0RdyO,
  output logic [HS_NUM_EP-1:0]       txRdyO,
  output logic [ADDR_W-1:0]          devAddrO,
  output logic                       stTglO,
  output logic                       stErrO,
  output logic                       stDirO,
  output logic                       stSetupO,
  output logic [CNT_W-1:0]           stCntO
);
  localparam int NUM_EP = HS_NUM_EP;

  strobe_t           strobe;
  rsp_e              rspKind;
  logic [NUM_EP-1:0] enable;

  assign enable    = {cfgI, 1'b1};
  assign respKindO = rspKind;

  usb_hs_ctrl #(.ADDR_W(ADDR_W), .EP_W(EP_W), .CNT_W(CNT_W), .NUM_EP(NUM_EP)) ctrl_i (
    .clk(clk), .rstN(rstN), .busResetI(busResetI),
    .tokValidI(tokValidI), .tokKindI(tokKindI), .tokAddrI(tokAddrI), .tokEpI(tokEpI),
    .dataValidI(dataValidI), .dataPid1I(dataPid1I), .dataCntI(dataCntI),
    .dataErrI(dataErrI), .hostAckI(hostAckI), .devAddrI(devAddrO),
    .rc0RdyI(rc0RdyO), .txRdyI(txRdyO), .toggleI(toggleI), .stallI(stallI),
    .enableI(enable), .ctrlRdI(ctrlRdI), .txCntI(txCntI),
    .respValidO(respValidO), .respKindO(rspKind), .respCntO(respCntO),
    .strobeO(strobe)
  );

  usb_hs_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_EP(NUM_EP)) dp_i (
    .clk(clk), .rstN(rstN), .busResetI(busResetI), .addrWrI(addrWrI), .addrI(addrI),
    .dataPid1I(dataPid1I), .dataCntI(dataCntI), .rc0RdySetI(rc0RdySetI),
    .txRdySetI(txRdySetI), .strobeI(strobe), .devAddrO(devAddrO), .rc0RdyO(rc0RdyO),
    .txRdyO(txRdyO), .rxFifoWeO(rxFifoWeO), .rxDoneO(rxDoneO), .txDoneO(txDoneO),
    .stTglO(stTglO), .stErrO(stErrO), .stDirO(stDirO), .stSetupO(stSetupO),
    .stCntO(stCntO)
  );
endmodule

// File: tb/usb_ep_handshake_tb.sv
module usb_ep_handshake_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 0, addrWr = 0, tokValid = 0, dataValid = 0, dataPid1 = 0;
  logic dataErr = 0, hostAck = 0, rc0Set = 0, ctrlRd = 0;
  logic [6:0] addrIn = 0, tokAddr = 0;
  logic [1:0] tokKind = 0;
  logic [3:0] tokEp = 0, dataCnt = 0;
  logic [2:0] txSet = 0, toggle = 0, stall = 0;
  logic [1:0] cfg = 0;
  logic [11:0] txCnt = 0;

  logic respValid, rxWe, rxDone, rc0Rdy, stTgl, stErr, stDir, stSetup;
  logic [2:0] respKind, txDone, txRdy;
  logic [3:0] respCnt, stCnt;
  logic [6:0] devAddr;

  int nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_handshake dut_i (
    .clk(clk), .rstN(rstN), .busResetI(busReset), .addrWrI(addrWr), .addrI(addrIn),
    .tokValidI(tokValid), .tokKindI(tokKind), .tokAddrI(tokAddr), .tokEpI(tokEp),
    .dataValidI(dataValid), .dataPid1I(dataPid1), .dataCntI(dataCnt), .dataErrI(dataErr),
    .hostAckI(hostAck), .rc0RdySetI(rc0Set), .txRdySetI(txSet), .toggleI(toggle),
    .stallI(stall), .cfgI(cfg), .ctrlRdI(ctrlRd), .txCntI(txCnt),
    .respValidO(respValid), .respKindO(respKind), .respCntO(respCnt),
    .rxFifoWeO(rxWe), .rxDoneO(rxDone), .txDoneO(txDone), .rc0RdyO(rc0Rdy),
    .txRdyO(txRdy), .devAddrO(devAddr), .stTglO(stTgl), .stErrO(stErr),
    .stDirO(stDir), .stSetupO(stSetup), .stCntO(stCnt)
  );

  // behavioural reference model
  int mState = 0, mAckEp = 0;
  logic mRespV = 0, mWe = 0, mRxDone = 0, mRc0Rdy = 0;
  logic mTgl = 0, mErr = 0, mDir = 0, mSetup = 0;
  logic [2:0] mRespK = 0, mTxDone = 0, mTxRdy = 0;
  logic [3:0] mRespC = 0, mCnt = 0;
  logic [6:0] mAddr = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mAckEp = 0; mRespV = 0; mRespK = 0; mRespC = 0; mWe = 0;
      mRxDone = 0; mTxDone = 0; mRc0Rdy = 0; mTxRdy = 0; mAddr = 0;
      mTgl = 0; mErr = 0; mDir = 0; mSetup = 0; mCnt = 0;
    end else begin
      bit take, setupT, bad;
      logic [2:0] ackV;
      int ep;
      take = 0; setupT = 0; bad = 0; ackV = 0;
      mRespV = 0; mRespK = 0; mRespC = 0;
      ep = int'(tokEp);
      if (busReset) mState = 0;
      else if (tokValid) begin
        mState = 0;
        if (tokAddr == mAddr) begin
          if (tokKind == 2 && ep == 0) mState = 1;
          else if (tokKind == 0 && ep == 0) mState = 2;
          else if (tokKind == 1 && (ep == 0 || (ep >= 1 && ep <= 2 && cfg[ep-1]))) begin
            mRespV = 1;
            if (stall[ep]) mRespK = 4;
            else if (!mTxRdy[ep]) mRespK = 3;
            else begin
              mRespK = toggle[ep] ? 3'd1 : 3'd0;
              mRespC = txCnt[ep*4 +: 4];
              mState = 3;
              mAckEp = ep;
            end
          end
        end
      end else if (dataValid && (mState == 1 || mState == 2)) begin
        if (dataErr) bad = 1;
        else if (mState == 1) begin take = 1; setupT = 1; mRespV = 1; mRespK = 2; end
        else if (stall[0] || (ctrlRd && (!dataPid1 || dataCnt != 0))) begin mRespV = 1; mRespK = 4; end
        else if (!mRc0Rdy) begin mRespV = 1; mRespK = 3; end
        else begin take = 1; mRespV = 1; mRespK = 2; end
        mState = 0;
      end else if (hostAck && mState == 3) begin
        ackV[mAckEp] = 1'b1;
        mState = 0;
      end
      if (busReset) mAddr = 0;
      else if (addrWr) mAddr = addrIn;
      mWe = take; mRxDone = take; mTxDone = ackV;
      if (take) begin
        mTgl = dataPid1; mErr = 0; mDir = 0; mSetup = setupT; mCnt = dataCnt; mRc0Rdy = 0;
      end else if (rc0Set) mRc0Rdy = 1;
      if (bad) mErr = 1;
      if (ackV[0]) mDir = 1;
      for (int i = 0; i < 3; i++) begin
        if (ackV[i]) mTxRdy[i] = 0;
        else if (txSet[i]) mTxRdy[i] = 1;
      end
    end
  end

  // per-cycle comparison, sampled away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      logic [39:0] act, exp;
      act = {respValid, respValid ? respKind : 3'd0, respValid ? respCnt : 4'd0, rxWe, rxDone,
             txDone, rc0Rdy, txRdy, stTgl, stErr, stDir, stSetup, stCnt, devAddr, 8'd0};
      exp = {mRespV, mRespV ? mRespK : 3'd0, mRespV ? mRespC : 4'd0, mWe, mRxDone,
             mTxDone, mRc0Rdy, mTxRdy, mTgl, mErr, mDir, mSetup, mCnt, mAddr, 8'd0};
      nChecks++;
      if (act !== exp) begin
        nFails++;
        $display("FAIL %s model compare: actual %h expected %h at %0t", curReq, act, exp, $time);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendTok(input logic [1:0] k, input logic [6:0] a, input logic [3:0] ep);
    @(negedge clk); tokValid = 1; tokKind = k; tokAddr = a; tokEp = ep;
    @(negedge clk); tokValid = 0;
  endtask

  task automatic sendData(input logic p1, input logic [3:0] c, input logic err);
    @(negedge clk); dataValid = 1; dataPid1 = p1; dataCnt = c; dataErr = err;
    @(negedge clk); dataValid = 0; dataErr = 0;
  endtask

  task automatic sendAck();
    @(negedge clk); hostAck = 1;
    @(negedge clk); hostAck = 0;
  endtask

  task automatic setRc0();
    @(negedge clk); rc0Set = 1;
    @(negedge clk); rc0Set = 0;
  endtask

  task automatic setTx(input logic [2:0] m);
    @(negedge clk); txSet = m;
    @(negedge clk); txSet = 0;
  endtask

  task automatic writeAddr(input logic [6:0] a);
    @(negedge clk); addrWr = 1; addrIn = a;
    @(negedge clk); addrWr = 0;
  endtask

  task automatic pulseBusReset();
    @(negedge clk); busReset = 1;
    @(negedge clk); busReset = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R1";
    chk("R1", "address", devAddr, 0);
    chk("R1", "ready flags", {rc0Rdy, txRdy}, 0);
    chk("R1", "reply", respValid, 0);

    // R2 address filtering and bus reset
    curReq = "R2";
    writeAddr(7'd5);
    chk("R2", "address load", devAddr, 5);
    setTx(3'b001);
    sendTok(2'd1, 7'd3, 4'd0);
    chk("R2", "foreign address silent", respValid, 0);
    sendTok(2'd1, 7'd5, 4'd0);
    chk("R2", "own address answered", respValid, 1);
    pulseBusReset();
    chk("R2", "bus reset address", devAddr, 0);
    chk("R2", "ready kept", txRdy[0], 1);

    // R3 SETUP data always accepted
    curReq = "R3";
    stall = 3'b001;
    sendTok(2'd2, 7'd0, 4'd0);
    sendData(1'b0, 4'd8, 1'b0);
    chk("R3", "setup ack", respKind, 2);
    chk("R3", "setup write", rxWe, 1);
    chk("R3", "setup status", {stSetup, stDir, stTgl, stCnt}, {1'b1, 1'b0, 1'b0, 4'd8});
    stall = 0;

    // R5 NAK while receive-ready clear
    curReq = "R5";
    sendTok(2'd0, 7'd0, 4'd0);
    sendData(1'b1, 4'd3, 1'b0);
    chk("R5", "nak", {respValid, respKind}, {1'b1, 3'd3});
    chk("R5", "status kept", stCnt, 8);

    // R4 OUT accepted when ready
    curReq = "R4";
    setRc0();
    sendTok(2'd0, 7'd0, 4'd0);
    sendData(1'b1, 4'd3, 1'b0);
    chk("R4", "out ack", respKind, 2);
    chk("R4", "ready cleared", rc0Rdy, 0);
    chk("R4", "out status", {stSetup, stTgl, stCnt}, {1'b0, 1'b1, 4'd3});

    // R6 stall priority
    curReq = "R6";
    setRc0();
    stall = 3'b001;
    sendTok(2'd0, 7'd0, 4'd0);
    sendData(1'b1, 4'd1, 1'b0);
    chk("R6", "out stall", respKind, 4);
    chk("R6", "ready kept", rc0Rdy, 1);
    sendTok(2'd1, 7'd0, 4'd0);
    chk("R6", "in stall", respKind, 4);
    stall = 0;

    // R7 control-read rule
    curReq = "R7";
    ctrlRd = 1;
    sendTok(2'd0, 7'd0, 4'd0);
    sendData(1'b0, 4'd0, 1'b0);
    chk("R7", "data0 stall", respKind, 4);
    sendTok(2'd0, 7'd0, 4'd0);
    sendData(1'b1, 4'd2, 1'b0);
    chk("R7", "count stall", respKind, 4);
    sendTok(2'd0, 7'd0, 4'd0);
    sendData(1'b1, 4'd0, 1'b0);
    chk("R7", "zero length ack", respKind, 2);
    ctrlRd = 0;

    // R8 and R9 IN data, toggle, ack
    curReq = "R8";
    toggle = 3'b001;
    txCnt = 12'h705;
    sendTok(2'd1, 7'd0, 4'd0);
    chk("R8", "in data1", {respKind, respCnt}, {3'd1, 4'd5});
    curReq = "R9";
    sendTok(2'd1, 7'd0, 4'd0);
    chk("R9", "ready held without ack", txRdy[0], 1);
    sendAck();
    chk("R9", "done pulse", txDone, 3'b001);
    chk("R9", "ready cleared", txRdy[0], 0);
    chk("R9", "dir in", stDir, 1);
    curReq = "R8";
    sendTok(2'd1, 7'd0, 4'd0);
    chk("R8", "in nak", respKind, 3);

    // R10 endpoints 1 and 2
    curReq = "R10";
    setTx(3'b110);
    sendTok(2'd1, 7'd0, 4'd1);
    chk("R10", "unconfigured silent", respValid, 0);
    cfg = 2'b11;
    sendTok(2'd1, 7'd0, 4'd1);
    chk("R10", "ep1 data0", {respValid, respKind, respCnt}, {1'b1, 3'd0, 4'd0});
    sendAck();
    chk("R10", "ep1 done", txDone, 3'b010);
    sendTok(2'd0, 7'd0, 4'd2);
    sendData(1'b1, 4'd1, 1'b0);
    chk("R10", "ep2 out silent", respValid, 0);
    sendTok(2'd1, 7'd0, 4'd5);
    chk("R10", "ep5 silent", respValid, 0);
    stall = 3'b100;
    sendTok(2'd1, 7'd0, 4'd2);
    chk("R10", "ep2 stall", respKind, 4);
    stall = 0;
    txCnt = 12'h700;
    sendTok(2'd1, 7'd0, 4'd2);
    chk("R10", "ep2 count", respCnt, 7);

    // R11 corrupt data
    curReq = "R11";
    setRc0();
    sendTok(2'd0, 7'd0, 4'd0);
    sendData(1'b1, 4'd4, 1'b1);
    chk("R11", "silent", respValid, 0);
    chk("R11", "err flag", stErr, 1);
    chk("R11", "ready kept", rc0Rdy, 1);
    sendTok(2'd2, 7'd0, 4'd0);
    sendData(1'b0, 4'd6, 1'b1);
    chk("R11", "setup err silent", respValid, 0);
    sendTok(2'd0, 7'd0, 4'd0);
    sendData(1'b0, 4'd4, 1'b0);
    chk("R11", "err cleared", stErr, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule